// File: doc/BRIEF.md
# Bytecode Dispatch Table-Index Unit

This unit sits beside the return path of a small processor core and turns certain returns into a hidden dispatch to a bytecode handler. A return normally jumps to the address that the core has popped from its call stack. When that address falls inside a reserved window of eight addresses, no jump is taken and the stack is left as it is. The unit instead takes the next bytecode byte from a first-word-fall-through FIFO and uses some of its bits to index a 512-entry, 32-bit lookup RAM. It then issues a branch to the handler address held in the entry and loads the entry's 22-bit skip pattern.

The low three bits of the window address choose how many bytecode bits form the index, so one return target sets up tables of 256 down to 2 entries. Bit 0 of a configured base chooses whether those bits come from the top or the bottom of the byte. The RAM address is the base with the index field cleared, ORed with the index. There is no carry chain, so every table must sit on a boundary that matches its size. The stack is never popped on a window return, so one push of a window address keeps the interpreter loop going for as long as handlers return.

Top module: `bytecode_dispatch`

## Requirements
- R1: A return (`ret_valid`) accepted while `ret_ready` is high, with `ret_target` in 0x1F8..0x1FF, starts a dispatch. `ret_ready` is low from the next cycle, and `ret_jump` stays low.
- R2: A return accepted while ready with a target outside the window raises `ret_jump` and `stack_pop` in the same cycle, with `jump_target` equal to `ret_target`. No dispatch starts.
- R3: `stack_pop` is never high while `ret_valid` presents a target inside the window.
- R4: The index width is 8 minus `ret_target[2:0]`, so 0x1F8 uses all 8 bits, 0x1FC uses 4 bits and 0x1FF uses 1 bit.
- R5: Base bit 0 set to 1 selects the most significant bits: the index is the byte shifted right by `ret_target[2:0]`. Bit 0 set to 0 selects the least significant bits: the index is the byte ANDed with a mask of width-many ones.
- R6: `lut_addr` is the 9-bit base, with its low width-many bits (bit 0 always among them) forced to zero, ORed with the index. There is no addition.
- R7: Each dispatch pops the FIFO (`fifo_pop`) exactly once, and only in a cycle where `fifo_rdy` is high. While the FIFO is empty the dispatch waits.
- R8: `lut_rd_en` is high in the same cycle as the pop, carrying `lut_addr`. The RAM returns `lut_rd_data` in the following cycle.
- R9: `br_valid` is a one-cycle pulse in the cycle after the RAM data returns. It carries `br_target` equal to entry bits [9:0] and `br_skip` equal to entry bits [31:10].
- R10: Each dispatch overwrites all 22 bits of `br_skip`, so no bit pending from the previous handler survives. `br_skip` changes only when `br_valid` pulses.
- R11: While a dispatch is in progress, `ret_ready` is low and any return presented is ignored: no jump, no pop, and no second dispatch. `ret_ready` is high again in the cycle `br_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | Core presents a return this cycle |
| ret_target | input | 10 | Address at the top of the call stack |
| base_cfg | input | 9 | Table base; bit 0 selects orientation |
| ret_ready | output | 1 | Unit idle; a return can be accepted |
| ret_jump | output | 1 | Ordinary return jump taken |
| jump_target | output | 10 | Target of the ordinary jump |
| stack_pop | output | 1 | Pop the call stack |
| fifo_rdy | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Consume the FIFO head byte |
| lut_rd_en | output | 1 | Lookup RAM read strobe |
| lut_addr | output | 9 | Lookup RAM read address |
| lut_rd_data | input | 32 | Lookup RAM data, one cycle after the strobe |
| br_valid | output | 1 | Branch-with-skip pulse |
| br_target | output | 10 | Handler address |
| br_skip | output | 22 | Skip pattern that replaces the pending one |

## Verification
On every cycle the assertions check the handshake timing. They cover the split between window and ordinary returns, the absence of any pop for a window return, and pops happening only when the FIFO has data. They also check that a read is followed by a single branch pulse carrying the returned entry, that returns are refused while busy, and that the skip pattern changes only on a pulse. The exact table address is checked only by the bench scenarios, across every width, both orientations, misaligned bases and edge byte values, because it depends on the base and byte captured several cycles apart. The same holds for waiting on an empty FIFO for several cycles.

// File: rtl/bcd_pkg.sv
// Package: shared widths, entry layout and sequencer states for the
// bytecode dispatch unit. Assumes a byte-wide bytecode and a 9-bit lookup RAM.
package bcd_pkg;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = $clog2(BYTE_W);
    localparam int LUT_AW  = 9;
    localparam int TGT_W   = 10;
    localparam int SKIP_W  = 22;
    localparam int ENTRY_W = TGT_W + SKIP_W;
    localparam int WIDTH_W = SEL_W + 1;

    // Table entry: skip pattern in the upper bits, handler address below.
    typedef struct packed {
        logic [SKIP_W-1:0] skip;
        logic [TGT_W-1:0]  target;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOOK  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/bcd_window_decode.sv
// Window decoder: flags a return target that lies in the reserved
// eight-address window and extracts the width selector from its low bits.
// Assumes WIN_BASE is aligned to 2**SEL_W.
module bcd_window_decode
    import bcd_pkg::*;
#(
    parameter logic [TGT_W-1:0] WIN_BASE = 10'h1F8
) (
    input  logic [TGT_W-1:0] target,
    output logic             in_win,
    output logic [SEL_W-1:0] sel
);
    localparam int TAG_W = TGT_W - SEL_W;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[TGT_W-1:SEL_W];

    // Compare the upper bits of the target with the window tag.
    always_comb begin
        in_win = (target[TGT_W-1:SEL_W] == WIN_TAG);
        sel    = target[SEL_W-1:0];
    end
endmodule

// File: rtl/bcd_index_former.sv
// Index former: builds the lookup RAM address from a base and a bit field
// of the bytecode. Field width is BYTE_W minus sel; base bit 0 picks the
// high (1) or low (0) end of the byte. The result is a bitwise merge of the
// base and the index, with no adder, so tables must be aligned to their size.
module bcd_index_former
    import bcd_pkg::*;
(
    input  logic [BYTE_W-1:0] code_byte,
    input  logic [SEL_W-1:0]  sel,
    input  logic [LUT_AW-1:0] base,
    output logic [LUT_AW-1:0] addr
);
    logic [WIDTH_W-1:0] width;
    logic [LUT_AW-1:0]  field_mask;
    logic [BYTE_W-1:0]  idx_hi;
    logic [BYTE_W-1:0]  idx_lo;
    logic [LUT_AW-1:0]  idx;

    // Derive the field width and a mask of that many ones.
    always_comb begin
        width      = WIDTH_W'(BYTE_W) - WIDTH_W'(sel);
        field_mask = (LUT_AW'(1) << width) - LUT_AW'(1);
    end

    // Form both candidate indices and pick one by the base orientation bit.
    always_comb begin
        idx_hi = code_byte >> sel;
        idx_lo = code_byte & field_mask[BYTE_W-1:0];
        idx    = LUT_AW'(base[0] ? idx_hi : idx_lo);
    end

    // Per address bit: the index inside the field, the base above it.
    for (genvar b = 0; b < LUT_AW; b++) begin : g_addr_bit
        assign addr[b] = field_mask[b] ? idx[b] : base[b];
    end
endmodule

// File: rtl/bcd_sequencer.sv
// Dispatch sequencer: accepts a window return while idle, captures the
// width selector and base, waits for a FIFO byte, issues one RAM read,
// then registers a one-cycle branch pulse with target and skip pattern.
// Assumes the lookup RAM returns data one cycle after its read strobe.
module bcd_sequencer
    import bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              in_win,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [LUT_AW-1:0] base_in,
    input  logic              fifo_rdy,
    input  logic [ENTRY_W-1:0] entry_raw,
    output logic              idle,
    output logic              take_byte,
    output logic [SEL_W-1:0]  cap_sel,
    output logic [LUT_AW-1:0] cap_base,
    output logic              br_valid,
    output logic [TGT_W-1:0]  br_target,
    output logic [SKIP_W-1:0] br_skip
);
    seq_state_t state_q, state_d;
    entry_t     entry;
    logic       start;

    // Decode the current state into handshake strobes.
    always_comb begin
        entry     = entry_t'(entry_raw);
        idle      = (state_q == ST_IDLE);
        start     = idle && ret_valid && in_win;
        take_byte = (state_q == ST_FETCH) && fifo_rdy;
    end

    // Next-state logic for the three-step dispatch.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_FETCH;
            ST_FETCH: if (take_byte) state_d = ST_LOOK;
            ST_LOOK:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the width selector and base when a dispatch starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_sel  <= '0;
            cap_base <= '0;
        end else if (start) begin
            cap_sel  <= sel_in;
            cap_base <= base_in;
        end
    end

    // Register the branch pulse and replace the whole skip pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_valid  <= 1'b0;
            br_target <= '0;
            br_skip   <= '0;
        end else if (state_q == ST_LOOK) begin
            br_valid  <= 1'b1;
            br_target <= entry.target;
            br_skip   <= entry.skip;
        end else begin
            br_valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/bytecode_dispatch.sv
// Top: hidden bytecode dispatch on returns into a reserved window.
// Ordinary returns pass straight through as jump plus stack pop; window
// returns leave the stack alone and run the fetch, lookup and branch sequence.
// Assumes a first-word-fall-through FIFO and a one-cycle-latency lookup RAM.
module bytecode_dispatch
    import bcd_pkg::*;
#(
    parameter logic [TGT_W-1:0] WIN_BASE = 10'h1F8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_valid,
    input  logic [TGT_W-1:0]   ret_target,
    input  logic [LUT_AW-1:0]  base_cfg,
    output logic               ret_ready,
    output logic               ret_jump,
    output logic [TGT_W-1:0]   jump_target,
    output logic               stack_pop,
    input  logic               fifo_rdy,
    input  logic [BYTE_W-1:0]  fifo_data,
    output logic               fifo_pop,
    output logic               lut_rd_en,
    output logic [LUT_AW-1:0]  lut_addr,
    input  logic [ENTRY_W-1:0] lut_rd_data,
    output logic               br_valid,
    output logic [TGT_W-1:0]   br_target,
    output logic [SKIP_W-1:0]  br_skip
);
    logic              in_win;
    logic [SEL_W-1:0]  sel;
    logic              idle;
    logic              take_byte;
    logic [SEL_W-1:0]  cap_sel;
    logic [LUT_AW-1:0] cap_base;

    bcd_window_decode #(.WIN_BASE(WIN_BASE)) u_win (
        .target (ret_target),
        .in_win (in_win),
        .sel    (sel)
    );

    bcd_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_valid (ret_valid),
        .in_win    (in_win),
        .sel_in    (sel),
        .base_in   (base_cfg),
        .fifo_rdy  (fifo_rdy),
        .entry_raw (lut_rd_data),
        .idle      (idle),
        .take_byte (take_byte),
        .cap_sel   (cap_sel),
        .cap_base  (cap_base),
        .br_valid  (br_valid),
        .br_target (br_target),
        .br_skip   (br_skip)
    );

    bcd_index_former u_idx (
        .code_byte (fifo_data),
        .sel       (cap_sel),
        .base      (cap_base),
        .addr      (lut_addr)
    );

    // Route the return path and the fetch strobes to the ports.
    always_comb begin
        ret_ready   = idle;
        ret_jump    = idle && ret_valid && !in_win;
        stack_pop   = ret_jump;
        jump_target = ret_target;
        fifo_pop    = take_byte;
        lut_rd_en   = take_byte;
    end
endmodule

// File: rtl/bcd_checker.sv
// Checker: port-level timing properties of the dispatch unit, bound to the top.
module bcd_checker
    import bcd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ret_valid,
    input logic [TGT_W-1:0]   ret_target,
    input logic               ret_ready,
    input logic               ret_jump,
    input logic               stack_pop,
    input logic               fifo_rdy,
    input logic               fifo_pop,
    input logic               lut_rd_en,
    input logic [ENTRY_W-1:0] lut_rd_data,
    input logic               br_valid,
    input logic [TGT_W-1:0]   br_target,
    input logic [SKIP_W-1:0]  br_skip
);
    logic win_hit;
    assign win_hit = (ret_target[TGT_W-1:SEL_W] == 7'h3F);

    // R1: accepted window return makes the unit busy next cycle.
    a_r1_dispatch_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_ready && win_hit) |=> !ret_ready);

    // R1: a window return never takes the ordinary jump.
    a_r1_no_jump_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && win_hit) |-> !ret_jump);

    // R2: accepted return outside the window jumps at once.
    a_r2_outside_jumps: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_ready && !win_hit) |-> (ret_jump && stack_pop));

    // R3: window returns leave the stack alone.
    a_r3_no_pop_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && win_hit) |-> !stack_pop);

    // R7: pops only when a byte is there, and one per dispatch.
    a_r7_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_rdy);
    a_r7_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    // R8: the RAM read travels with the pop.
    a_r8_read_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> lut_rd_en);

    // R9: pulse two cycles after the read, one cycle long, carrying the entry.
    a_r9_pulse_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        lut_rd_en |=> ##1 br_valid);
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> !br_valid);
    a_r9_entry_target: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (br_target == $past(lut_rd_data[TGT_W-1:0])));
    a_r9_entry_skip: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (br_skip == $past(lut_rd_data[ENTRY_W-1:TGT_W])));

    // R10: the skip pattern moves only on a branch pulse.
    a_r10_skip_held: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> $stable(br_skip));

    // R11: a busy unit neither jumps nor pops.
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_ready |-> (!ret_jump && !stack_pop));
    a_r11_ready_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> ret_ready);
endmodule

bind bytecode_dispatch bcd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_valid   (ret_valid),
    .ret_target  (ret_target),
    .ret_ready   (ret_ready),
    .ret_jump    (ret_jump),
    .stack_pop   (stack_pop),
    .fifo_rdy    (fifo_rdy),
    .fifo_pop    (fifo_pop),
    .lut_rd_en   (lut_rd_en),
    .lut_rd_data (lut_rd_data),
    .br_valid    (br_valid),
    .br_target   (br_target),
    .br_skip     (br_skip)
);

// File: tb/bytecode_dispatch_tb.sv
// Bench: directed corners plus seeded random dispatches, with a behavioural
// lookup RAM and expected addresses computed bit by bit from the requirements.
module bytecode_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [9:0]  ret_target = '0;
    logic [8:0]  base_cfg = '0;
    logic        ret_ready, ret_jump, stack_pop;
    logic [9:0]  jump_target;
    logic        fifo_rdy = 1'b0;
    logic [7:0]  fifo_data = '0;
    logic        fifo_pop, lut_rd_en;
    logic [8:0]  lut_addr;
    logic [31:0] lut_rd_data = '0;
    logic        br_valid;
    logic [9:0]  br_target;
    logic [21:0] br_skip;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mem [512];

    always #2 clk = ~clk;

    bytecode_dispatch u_dut (.*);

    // Behavioural RAM with one cycle of read latency.
    always @(posedge clk) if (lut_rd_en) lut_rd_data <= mem[lut_addr];

    function automatic logic [31:0] mem_fn(int a);
        return (32'h9E3779B9 * (a + 1)) ^ (32'(a) << 13);
    endfunction

    // Expected address: low w bits from the index, upper bits from the base.
    function automatic logic [8:0] exp_addr(logic [2:0] sel, logic [8:0] base, logic [7:0] b);
        logic [8:0] r;
        int w;
        w = 8 - int'(sel);
        for (int i = 0; i < 9; i++) begin
            if (i < w) r[i] = base[0] ? b[int'(sel) + i] : b[i];
            else       r[i] = base[i];
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    logic [21:0] last_skip = '0;

    task automatic dispatch(logic [2:0] sel, logic [8:0] base, logic [7:0] b, int delay);
        logic [8:0] ea;
        ea = exp_addr(sel, base, b);
        @(negedge clk);
        ret_valid = 1'b1; ret_target = 10'h1F8 | 10'(sel); base_cfg = base;
        #1;
        check(ret_ready == 1'b1, "R1 ready before dispatch", 32'(ret_ready), 1);
        check(ret_jump == 1'b0, "R1 no jump on window", 32'(ret_jump), 0);
        check(stack_pop == 1'b0, "R3 no pop on window", 32'(stack_pop), 0);
        @(negedge clk);
        ret_valid = 1'b0; base_cfg = ~base;
        for (int d = 0; d < delay; d++) begin
            if (d == 0) begin ret_valid = 1'b1; ret_target = 10'h055; end
            #1;
            check(ret_ready == 1'b0, "R11 busy", 32'(ret_ready), 0);
            check(fifo_pop == 1'b0, "R7 wait on empty", 32'(fifo_pop), 0);
            if (d == 0) begin
                check(ret_jump == 1'b0 && stack_pop == 1'b0, "R11 return ignored while busy",
                      32'({ret_jump, stack_pop}), 0);
            end
            @(negedge clk);
            ret_valid = 1'b0;
        end
        fifo_rdy = 1'b1; fifo_data = b;
        #1;
        check(fifo_pop == 1'b1, "R7 pop with byte", 32'(fifo_pop), 1);
        check(lut_rd_en == 1'b1, "R8 read with pop", 32'(lut_rd_en), 1);
        check(lut_addr == ea, "R4 R5 R6 lookup address", 32'(lut_addr), 32'(ea));
        @(negedge clk);
        fifo_rdy = 1'b0; fifo_data = ~b;
        #1;
        check(br_valid == 1'b0, "R9 no early pulse", 32'(br_valid), 0);
        check(fifo_pop == 1'b0, "R7 single pop", 32'(fifo_pop), 0);
        check(br_skip == last_skip, "R10 skip held before pulse", 32'(br_skip), 32'(last_skip));
        @(negedge clk);
        check(br_valid == 1'b1, "R9 pulse", 32'(br_valid), 1);
        check(br_target == mem_fn(int'(ea))[9:0], "R9 target", 32'(br_target), 32'(mem_fn(int'(ea))[9:0]));
        check(br_skip == mem_fn(int'(ea))[31:10], "R10 skip replaced", 32'(br_skip), 32'(mem_fn(int'(ea))[31:10]));
        check(ret_ready == 1'b1, "R11 ready at pulse", 32'(ret_ready), 1);
        last_skip = mem_fn(int'(ea))[31:10];
        @(negedge clk);
        check(br_valid == 1'b0, "R9 pulse one cycle", 32'(br_valid), 0);
        check(br_skip == last_skip, "R10 skip held after pulse", 32'(br_skip), 32'(last_skip));
    endtask

    task automatic plain_return(logic [9:0] t);
        @(negedge clk);
        ret_valid = 1'b1; ret_target = t;
        #1;
        check(ret_jump == 1'b1, "R2 jump outside window", 32'(ret_jump), 1);
        check(stack_pop == 1'b1, "R2 pop outside window", 32'(stack_pop), 1);
        check(jump_target == t, "R2 jump target", 32'(jump_target), 32'(t));
        @(negedge clk);
        ret_valid = 1'b0;
        #1;
        check(ret_ready == 1'b1, "R2 no dispatch started", 32'(ret_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 512; a++) mem[a] = mem_fn(a);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(ret_ready == 1'b1, "R11 reset idle", 32'(ret_ready), 1);
        check(br_valid == 1'b0, "R9 reset no pulse", 32'(br_valid), 0);
        check(fifo_pop == 1'b0, "R7 reset no pop", 32'(fifo_pop), 0);
        rst_n = 1'b1;
        check(br_skip == 22'd0, "R10 reset skip clear", 32'(br_skip), 0);

        plain_return(10'h1F7);
        plain_return(10'h200);
        plain_return(10'h000);
        dispatch(3'd0, 9'h100, 8'hA5, 0);
        dispatch(3'd0, 9'h101, 8'h3C, 1);
        dispatch(3'd0, 9'h0FF, 8'hFF, 2);
        dispatch(3'd4, 9'h1F1, 8'hB7, 0);
        dispatch(3'd4, 9'h1F0, 8'hB7, 0);
        dispatch(3'd7, 9'h1FF, 8'h80, 1);
        dispatch(3'd7, 9'h1FE, 8'h01, 0);
        dispatch(3'd7, 9'h1FE, 8'h80, 0);
        dispatch(3'd1, 9'h0E3, 8'hFE, 3);
        for (int n = 0; n < 60; n++) begin
            if (($urandom % 5) == 0) plain_return(10'($urandom % 504));
            dispatch(3'($urandom % 8), 9'($urandom % 512), 8'($urandom % 256), int'($urandom % 3));
        end
        finish_run();
    end
endmodule